// File: doc/BRIEF.md
# Interleaved Multistream AES-128 Round Engine

This block encrypts 128-bit blocks with AES-128, using one folded round of hardware that several independent streams share. The round logic is cut into `STAGES` register stages (1 to 4) that form a ring. Each register position in the ring is a slot that holds the state of one block, so up to `STAGES` blocks from different streams can be in flight at once. Each slot moves through the whole ring once per AES round and so gains one round per pass. A block finishes after ten passes.

A block enters through `in_block`, together with its cipher key on `in_key` and a stream label on `in_tag`. The initial key whitening is applied as the block enters. The block can enter only in a cycle when `slot_free` is high, which means the slot at the head of the ring is empty or is just finishing. In every cycle in which a slot is about to apply AddRoundKey, the engine asks an external per-stream key store for that stream's round key (`rk_req`, `rk_tag`, `rk_round`) and expects the key back on `rk_key` in the same cycle. A finished block leaves on `out_block` with its label on `out_tag`, and `done` is high for one cycle.

The round is split as follows. SubBytes uses computed substitution logic rather than block memory, and ShiftRows is only wiring. The MixColumns work is spread over a doubling step, a partial-sum step and a final-sum step, and AddRoundKey is folded into the final step. Round 10 bypasses MixColumns.

Top module: `mscipher_core`

## Requirements
- R1: After reset, `done` and `rk_req` are low and `slot_free` is high.
- R2: Every block comes out as its AES-128 ciphertext under the key that was supplied with it. This holds for both known-answer pairs used here. Key 000102…0f with plaintext 00112233…eeff gives 69c4e0d86a7b0430d8cdb78070b4c55a. Key 2b7e1516…4f3c with plaintext 3243f6a8…0734 gives 3925841d02dc09fbdc118597196a0b32.
- R3: Count the rising edge that accepts a block as edge 1. Its result is on the outputs during the cycle after edge 10·STAGES, which is 40 edges for the default STAGES of 4.
- R4: `out_tag` carries the `in_tag` value that was given with the block.
- R5: `in_valid` raised while `slot_free` is low is ignored. No block enters, and no extra `done` appears.
- R6: For each stream, `rk_round` runs 1, 2, …, 10 in order, once per round, with `rk_tag` equal to that block's tag.
- R7: `STAGES` blocks can be accepted on consecutive edges. They occupy every slot at once and come out on consecutive cycles in the order they went in, each one correct.
- R8: In the cycle when a slot shows `done`, `slot_free` is high. A block offered in that cycle is accepted and completes 10·STAGES edges later.
- R9: `done` is high for exactly one cycle per accepted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Offer a new block |
| in_tag | input | TAG_W | Stream label of the offered block |
| in_block | input | 128 | Plaintext block |
| in_key | input | 128 | Cipher key (round-0 key) of the offered block |
| slot_free | output | 1 | Head slot can take a block this cycle |
| rk_req | output | 1 | A round key is needed this cycle |
| rk_tag | output | TAG_W | Stream whose round key is needed |
| rk_round | output | 4 | Round number (1 to 10) of the key needed |
| rk_key | input | 128 | Round key returned by the external key store |
| done | output | 1 | Ciphertext valid this cycle |
| out_tag | output | TAG_W | Stream label of the ciphertext |
| out_block | output | 128 | Ciphertext block |

## Verification
The bench notes the clock-edge number at which each block is accepted. A monitor records the edge number after which every `done` pulse appears. Each recorded result must fall exactly 10·STAGES−1 edges after its accepting edge, so a result that arrives one cycle early or late fails even when its data is right. The refill case checks `done` and `slot_free` at the same sampling point before the accepting edge. The round-key sequence is watched on every cycle halfway between edges.

// File: rtl/mscipher_pkg.sv
package mscipher_pkg;

    localparam int BLK_W   = 128;
    localparam int NROUNDS = 10;

    // byte k of a block, k = 0 is the most significant byte
    function automatic logic [7:0] byte_at(input logic [BLK_W-1:0] blk, input int k);
        return blk[BLK_W-1-8*k -: 8];
    endfunction

    function automatic logic [7:0] xtime8(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul8(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime8(sh);
        end
        return acc;
    endfunction

    // state[row][col] sits at byte row + 4*col; row r rotates left by r
    function automatic logic [BLK_W-1:0] shift_rows(input logic [BLK_W-1:0] s);
        logic [BLK_W-1:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[BLK_W-1-8*(r+4*c) -: 8] = byte_at(s, r + 4*((c+r)%4));
        return o;
    endfunction

    function automatic logic [BLK_W-1:0] double_all(input logic [BLK_W-1:0] s);
        logic [BLK_W-1:0] o;
        for (int k = 0; k < 16; k++)
            o[BLK_W-1-8*k -: 8] = xtime8(byte_at(s, k));
        return o;
    endfunction

    // partial column sum: 2*a[i] ^ 3*a[i+1], with 3*x = 2*x ^ x
    function automatic logic [BLK_W-1:0] mix_partial(input logic [BLK_W-1:0] a,
                                                     input logic [BLK_W-1:0] d);
        logic [BLK_W-1:0] o;
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++)
                o[BLK_W-1-8*(4*c+i) -: 8] = byte_at(d, 4*c+i)
                                          ^ byte_at(d, 4*c+(i+1)%4)
                                          ^ byte_at(a, 4*c+(i+1)%4);
        return o;
    endfunction

    // remaining terms: a[i+2] ^ a[i+3]
    function automatic logic [BLK_W-1:0] mix_final(input logic [BLK_W-1:0] a,
                                                   input logic [BLK_W-1:0] p);
        logic [BLK_W-1:0] o;
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++)
                o[BLK_W-1-8*(4*c+i) -: 8] = byte_at(p, 4*c+i)
                                          ^ byte_at(a, 4*c+(i+2)%4)
                                          ^ byte_at(a, 4*c+(i+3)%4);
        return o;
    endfunction

endpackage

// File: rtl/sbox8.sv
module sbox8
    import mscipher_pkg::*;
(
    input  logic [7:0] sb_in,
    output logic [7:0] sb_out
);
    logic [7:0] inv;

    always_comb begin
        logic [7:0] p2, p3, p6, p7, p14, p15, p30, p31, p62, p63, p126, p127;
        // x^254 is the field inverse (and maps 0 to 0)
        p2   = gf_mul8(sb_in, sb_in);
        p3   = gf_mul8(p2, sb_in);
        p6   = gf_mul8(p3, p3);
        p7   = gf_mul8(p6, sb_in);
        p14  = gf_mul8(p7, p7);
        p15  = gf_mul8(p14, sb_in);
        p30  = gf_mul8(p15, p15);
        p31  = gf_mul8(p30, sb_in);
        p62  = gf_mul8(p31, p31);
        p63  = gf_mul8(p62, sb_in);
        p126 = gf_mul8(p63, p63);
        p127 = gf_mul8(p126, sb_in);
        inv  = gf_mul8(p127, p127);
    end

    assign sb_out = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                  ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;

endmodule

// File: rtl/sub_bytes.sv
module sub_bytes
    import mscipher_pkg::*;
(
    input  logic [BLK_W-1:0] sub_in,
    output logic [BLK_W-1:0] sub_out
);
    localparam int NBYTES = BLK_W / 8;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        sbox8 i_sbox (
            .sb_in  (sub_in [8*k +: 8]),
            .sb_out (sub_out[8*k +: 8])
        );
    end

endmodule

// File: rtl/mscipher_core.sv
module mscipher_core
    import mscipher_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int TAG_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [TAG_W-1:0]     in_tag,
    input  logic [BLK_W-1:0]     in_block,
    input  logic [BLK_W-1:0]     in_key,
    output logic                 slot_free,
    output logic                 rk_req,
    output logic [TAG_W-1:0]     rk_tag,
    output logic [3:0]           rk_round,
    input  logic [BLK_W-1:0]     rk_key,
    output logic                 done,
    output logic [TAG_W-1:0]     out_tag,
    output logic [BLK_W-1:0]     out_block
);
    // register cut points: after SubBytes/ShiftRows, after doubling,
    // after partial sums; the cut after AddRoundKey always exists
    localparam bit CUT_SB  = (STAGES >= 2);
    localparam bit CUT_DBL = (STAGES >= 3);
    localparam bit CUT_PRT = (STAGES >= 4);
    localparam int LAST    = 3;
    localparam logic [3:0] RND_LAST = 4'(NROUNDS);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [3:0]       rnd;
        logic [BLK_W-1:0] x;
        logic [BLK_W-1:0] y;
    } slot_t;

    typedef struct packed {
        slot_t [3:0] st;
    } ring_t;

    ring_t ring_d, ring_q;
    slot_t head;
    logic [BLK_W-1:0] sb_res;

    logic tail_busy;
    assign tail_busy = ring_q.st[LAST].valid && (ring_q.st[LAST].rnd != RND_LAST);

    // head of the ring: a continuing slot, a newly admitted block, or empty
    always_comb begin
        head = '0;
        if (tail_busy) begin
            head     = ring_q.st[LAST];
            head.rnd = ring_q.st[LAST].rnd + 4'd1;
        end else if (in_valid) begin
            head.valid = 1'b1;
            head.tag   = in_tag;
            head.rnd   = 4'd1;
            head.x     = in_block ^ in_key;
        end
    end

    sub_bytes i_sub_bytes (
        .sub_in  (head.x),
        .sub_out (sb_res)
    );

    always_comb begin
        slot_t n1, n2, n3, n4, s1, s2, s3;
        n1   = head;
        n1.x = shift_rows(sb_res);
        n1.y = '0;
        s1   = CUT_SB ? ring_q.st[0] : n1;

        n2   = s1;
        n2.y = double_all(s1.x);
        s2   = CUT_DBL ? ring_q.st[1] : n2;

        n3   = s2;
        n3.y = mix_partial(s2.x, s2.y);
        s3   = CUT_PRT ? ring_q.st[2] : n3;

        n4   = s3;
        n4.x = ((s3.rnd == RND_LAST) ? s3.x : mix_final(s3.x, s3.y)) ^ rk_key;
        n4.y = '0;

        ring_d.st[0] = n1;
        ring_d.st[1] = n2;
        ring_d.st[2] = n3;
        ring_d.st[3] = n4;

        rk_req   = s3.valid;
        rk_tag   = s3.tag;
        rk_round = s3.rnd;
    end

    always_ff @(posedge clk) begin
        if (rst) ring_q <= '0;
        else     ring_q <= ring_d;
    end

    assign slot_free = !tail_busy;
    assign done      = ring_q.st[LAST].valid && (ring_q.st[LAST].rnd == RND_LAST);
    assign out_tag   = ring_q.st[LAST].tag;
    assign out_block = ring_q.st[LAST].x;

    // R1: nothing completes in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !rk_req));

    // R5: a slot in round 1 was admitted STAGES edges earlier while free
    p_enter_when_free_r5: assert property (@(posedge clk) disable iff (rst)
        (ring_q.st[LAST].valid && ring_q.st[LAST].rnd == 4'd1)
        |-> $past(in_valid && slot_free, STAGES));

    // R6: a busy slot returns one pass later one round further on
    p_round_step_r6: assert property (@(posedge clk) disable iff (rst)
        tail_busy |-> ##STAGES (ring_q.st[LAST].valid &&
            ring_q.st[LAST].rnd == $past(ring_q.st[LAST].rnd, STAGES) + 4'd1));

    // R4: the slot keeps its stream label from pass to pass
    p_tag_kept_r4: assert property (@(posedge clk) disable iff (rst)
        tail_busy |-> ##STAGES (ring_q.st[LAST].tag == $past(ring_q.st[LAST].tag, STAGES)));

    // R6: key requests only name rounds 1..10
    p_key_round_range_r6: assert property (@(posedge clk) disable iff (rst)
        rk_req |-> (rk_round >= 4'd1 && rk_round <= RND_LAST));

endmodule

// File: tb/test_mscipher_core.sv
`timescale 1ns/1ps
module test_mscipher_core;
    localparam int STAGES = 4;
    localparam int TAG_W  = 2;
    localparam int LAT    = 10 * STAGES;
    localparam int NS     = 1 << TAG_W;

    localparam logic [127:0] K0 = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P0 = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] C0 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] K1 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] P1 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] C1 = 128'h3925841d02dc09fbdc118597196a0b32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [127:0] in_block = '0;
    logic [127:0] in_key = '0;
    logic slot_free, rk_req, done;
    logic [TAG_W-1:0] rk_tag, out_tag;
    logic [3:0] rk_round;
    logic [127:0] rk_key, out_block;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [127:0] rk_tab [NS][11];
    logic [7:0]   sb_tab [256];

    int           log_n;
    logic [TAG_W-1:0] log_tag [16];
    logic [127:0] log_blk [16];
    int           log_cyc [16];
    int           rk_bad = 0;
    logic [3:0]   rk_next [NS];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rk_key = (rk_round <= 4'd10) ? rk_tab[rk_tag][rk_round] : '0;

    mscipher_core #(.STAGES(STAGES), .TAG_W(TAG_W)) i_mscipher_core (
        .clk, .rst, .in_valid, .in_tag, .in_block, .in_key,
        .slot_free, .rk_req, .rk_tag, .rk_round, .rk_key,
        .done, .out_tag, .out_block
    );

    // result log and round-key order monitor (R6)
    always @(negedge clk) begin
        if (!rst && done && log_n < 16) begin
            log_tag[log_n] = out_tag;
            log_blk[log_n] = out_block;
            log_cyc[log_n] = cyc;
            log_n = log_n + 1;
        end
        if (!rst && rk_req) begin
            if (rk_round != rk_next[rk_tag]) rk_bad = rk_bad + 1;
            rk_next[rk_tag] = (rk_round == 4'd10) ? 4'd1 : rk_round + 4'd1;
        end
    end

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= t;
            t = t[7] ? ((t << 1) ^ 8'h1b) : (t << 1);
        end
        return r;
    endfunction

    task automatic build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] o;
            for (int y = 1; y < 256; y++)
                if (bmul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
            sb_tab[v] = o;
        end
    endtask

    task automatic load_key(input int tag, input logic [127:0] key);
        logic [31:0] w [44];
        logic [7:0] rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb_tab[t[31:24]] ^ rc, sb_tab[t[23:16]], sb_tab[t[15:8]], sb_tab[t[7:0]]};
                rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++)
            rk_tab[tag][r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    task automatic check(input string req, input string what, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // offer one block now; returns the accepting edge number
    task automatic put(input int tag, input logic [127:0] pt, output int acc);
        @(negedge clk);
        in_valid = 1'b1; in_tag = TAG_W'(tag); in_block = pt; in_key = rk_tab[tag][0];
        @(posedge clk); #1;
        acc = cyc;
        in_valid = 1'b0;
    endtask

    task automatic check_entry(input int idx, input int tag, input logic [127:0] ct,
                               input int acc);
        check("R2", "ciphertext", log_blk[idx], ct);
        check("R4", "out_tag", 128'(log_tag[idx]), 128'(tag));
        check("R3", "done edge", 128'(log_cyc[idx]), 128'(acc + LAT - 1));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "done", 128'(done), 128'(0));
        check("R1", "slot_free", 128'(slot_free), 128'(1));
        check("R1", "rk_req", 128'(rk_req), 128'(0));
    endtask

    task automatic t_single(input int tag, input logic [127:0] key, input logic [127:0] pt,
                            input logic [127:0] ct);
        int acc;
        load_key(tag, key);
        log_n = 0;
        put(tag, pt, acc);
        repeat (LAT + 5) @(posedge clk);
        @(negedge clk);
        check("R9", "done count", 128'(log_n), 128'(1));
        check_entry(0, tag, ct, acc);
    endtask

    task automatic t_full_busy();
        int acc [4];
        bit busy_ok = 1'b1;
        for (int i = 0; i < 4; i++) load_key(i, (i % 2) ? K1 : K0);
        log_n = 0;
        for (int i = 0; i < 4; i++) put(i, (i % 2) ? P1 : P0, acc[i]);
        // R5: offer a block while every slot is taken
        @(negedge clk);
        in_valid = 1'b1; in_tag = 2'd3; in_block = '1; in_key = rk_tab[3][0];
        repeat (20) begin
            @(negedge clk);
            if (slot_free !== 1'b0) busy_ok = 1'b0;
        end
        in_valid = 1'b0;
        check("R5", "slot_free low while full", 128'(busy_ok), 128'(1));
        repeat (LAT + 10) @(posedge clk);
        @(negedge clk);
        check("R5", "done count, ignored offer", 128'(log_n), 128'(4));
        for (int i = 0; i < 4; i++) begin
            check_entry(i, i, (i % 2) ? C1 : C0, acc[i]);
            check("R7", "back-to-back accept", 128'(acc[i]), 128'(acc[0] + i));
        end
    endtask

    task automatic t_refill();
        int acc [4];
        int acc4;
        for (int i = 0; i < 4; i++) load_key(i, (i % 2) ? K1 : K0);
        log_n = 0;
        for (int i = 0; i < 4; i++) put(i, (i % 2) ? P1 : P0, acc[i]);
        @(negedge clk);
        in_valid = 1'b1; in_tag = 2'd0; in_block = P0; in_key = rk_tab[0][0];
        while (slot_free !== 1'b1) @(negedge clk);
        check("R8", "done with slot_free", 128'(done), 128'(1));
        @(posedge clk); #1;
        acc4 = cyc;
        in_valid = 1'b0;
        check("R8", "refill edge", 128'(acc4), 128'(acc[0] + LAT));
        repeat (LAT + 10) @(posedge clk);
        @(negedge clk);
        check("R9", "done count", 128'(log_n), 128'(5));
        check_entry(4, 0, C0, acc4);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NS; i++) rk_next[i] = 4'd1;
        build_sbox();
        for (int i = 0; i < NS; i++) load_key(i, K0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single(0, K0, P0, C0);
        t_single(2, K1, P1, C1);
        t_full_busy();
        t_refill();
        check("R6", "round key order", 128'(rk_bad), 128'(0));
        finish_run();
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

endmodule